// File: doc/BRIEF.md
# Byte-Lane Bus Bridge with Misaligned Word Support

This block sits between a processor-side request port and a 16-bit memory built from two 8-bit banks. The processor asks for a byte or a 16-bit word, read or write, at any byte address. Words are little-endian: the low-order byte sits at the given address and the high-order byte at the next one. Bytes at even addresses are held in the low bank, on memory data bits 7..0. Bytes at odd addresses are held in the high bank, on bits 15..8.

A word at an even address moves in one bus cycle with both banks enabled. A word at an odd address is broken into two byte cycles. The first cycle uses the high bank at the current word address. The second uses the low bank at the following word address. On a write the block swaps the two CPU bytes across the lanes, and on a read it swaps them back, so software sees no alignment restriction. A `mem_ready` input stretches any bus cycle. A one-cycle `done` pulse marks the end of the last bus cycle of a request.

Top module: `lane_bridge`

## Requirements
- R1: While reset is high and in the first cycle after it, `busy`, `done` and every bit of `mem_en` are 0.
- R2: A byte access enables only one bank, chosen by address bit 0 (`mem_en` = 2'b01 for even, 2'b10 for odd), on word address `addr >> 1`. A byte write places `req_wdata[7:0]` on that bank's lane and leaves the other bank's byte unchanged.
- R3: A byte read returns the selected lane's byte in `rdata[7:0]`, with `rdata[15:8]` = 0.
- R4: A word at an even address takes exactly one bus cycle with `mem_en` = 2'b11. The low CPU byte travels on the low lane and the high CPU byte on the high lane.
- R5: A word at an odd address takes exactly two bus cycles. The first has `mem_en` = 2'b10 at `addr >> 1`. The second has `mem_en` = 2'b01 at `(addr >> 1) + 1`, wrapping to 0 at the top of the space.
- R6: A misaligned word read returns `{byte[addr+1], byte[addr]}` in `rdata`, with the byte address wrapping.
- R7: A misaligned word write stores `req_wdata[7:0]` at `addr` and `req_wdata[15:8]` at `addr+1`, and no other byte changes.
- R8: While a bus cycle is under way and `mem_ready` is low, `mem_en`, `mem_addr`, `mem_we` and `mem_wdata` hold their values.
- R9: `busy` is high from the cycle after acceptance until the final bus cycle completes. `done` then pulses high for exactly one cycle, with `busy` low and `mem_en` = 0. `rdata` is valid while `done` is high.
- R10: A request presented while `busy` is high is ignored and causes no memory access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present; accepted when not busy |
| req_write | input | 1 | 1 = write, 0 = read |
| req_word | input | 1 | 1 = 16-bit word, 0 = byte |
| req_addr | input | ADDR_W | Byte address |
| req_wdata | input | 2*BYTE_W | Write data, low byte in bits 7..0 |
| busy | output | 1 | Request in progress |
| done | output | 1 | One-cycle completion pulse |
| rdata | output | 2*BYTE_W | Read result |
| mem_addr | output | ADDR_W-1 | Word address to both banks |
| mem_en | output | 2 | Bank enables, bit 0 low bank, bit 1 high bank |
| mem_we | output | 1 | Write strobe for the enabled banks |
| mem_wdata | output | 2*BYTE_W | Lane data to memory |
| mem_rdata | input | 2*BYTE_W | Lane data from memory |
| mem_ready | input | 1 | Completes the current bus cycle |

## Verification
The bench aims at odd-address words, and at the highest odd address in particular, where the second word address must wrap to zero. A design that forgot the lane swap would return the two bytes reversed or store them in the wrong banks. A design that missed the wrap would write outside the space. Random ready stalls test whether the bus outputs hold steady while the memory is not ready; a design that let them drift would be caught by its strobe or address changing mid-cycle. A stray request held high during a transfer shows whether the block wrongly accepts work while busy, and byte writes are followed by checks of the neighbouring byte to catch a lane enabled too widely.

// File: rtl/lane_pkg.sv
package lane_pkg;
  typedef enum logic [1:0] {
    PH_IDLE   = 2'd0,
    PH_FIRST  = 2'd1,
    PH_SECOND = 2'd2
  } phase_e;
endpackage

// File: rtl/lane_map.sv
// Computes bank enables, word address and lane data for one bus cycle.
module lane_map #(
  parameter int ADDR_W = 16,
  parameter int BYTE_W = 8
) (
  input  logic                  second,
  input  logic                  word,
  input  logic [ADDR_W-1:0]     addr,
  input  logic [2*BYTE_W-1:0]   wdata,
  output logic [1:0]            en,
  output logic [ADDR_W-2:0]     waddr,
  output logic [2*BYTE_W-1:0]   lanes
);
  localparam int WA_W = ADDR_W - 1;
  localparam logic [WA_W-1:0] ONE = WA_W'(1);
  localparam logic [BYTE_W-1:0] ZB = '0;

  logic              odd;
  logic [WA_W-1:0]   base;
  logic [BYTE_W-1:0] lo_b, hi_b;

  assign odd  = addr[0];
  assign base = addr[ADDR_W-1:1];
  assign lo_b = wdata[BYTE_W-1:0];
  assign hi_b = wdata[2*BYTE_W-1:BYTE_W];

  always_comb begin
    waddr = base;
    if (second) begin
      en    = 2'b01;
      waddr = base + ONE;
      lanes = {ZB, hi_b};
    end else if (word && !odd) begin
      en    = 2'b11;
      lanes = wdata;
    end else if (odd) begin
      en    = 2'b10;
      lanes = {lo_b, ZB};
    end else begin
      en    = 2'b01;
      lanes = {ZB, lo_b};
    end
  end
endmodule

// File: rtl/lane_seq.sv
// Request sequencer: idle, first bus cycle, optional second bus cycle.
module lane_seq (
  input  logic clk,
  input  logic rst,
  input  logic req_valid,
  input  logic split,
  input  logic mem_ready,
  output logic accept,
  output logic advance,
  output logic finish,
  output logic complete,
  output logic in_second,
  output logic busy,
  output logic done
);
  import lane_pkg::*;
  phase_e ph;

  assign accept    = (ph == PH_IDLE) && req_valid;
  assign complete  = (ph != PH_IDLE) && mem_ready;
  assign advance   = (ph == PH_FIRST) && mem_ready && split;
  assign finish    = complete && !advance;
  assign in_second = (ph == PH_SECOND);

  always_ff @(posedge clk) begin
    if (rst) begin
      ph   <= PH_IDLE;
      busy <= 1'b0;
      done <= 1'b0;
    end else begin
      done <= finish;
      if (accept) begin
        ph   <= PH_FIRST;
        busy <= 1'b1;
      end else if (advance) begin
        ph <= PH_SECOND;
      end else if (finish) begin
        ph   <= PH_IDLE;
        busy <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/lane_gather.sv
// Assembles read data from the lanes, undoing the swap for split words.
module lane_gather #(
  parameter int BYTE_W = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                capture,
  input  logic                second,
  input  logic                word,
  input  logic                odd,
  input  logic [2*BYTE_W-1:0] mem_rdata,
  output logic [2*BYTE_W-1:0] rdata
);
  localparam logic [BYTE_W-1:0] ZB = '0;
  logic [BYTE_W-1:0] lane [2];

  for (genvar b = 0; b < 2; b++) begin : g_lane
    assign lane[b] = mem_rdata[b*BYTE_W +: BYTE_W];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= '0;
    end else if (capture) begin
      if (second)
        rdata[2*BYTE_W-1:BYTE_W] <= lane[0];
      else if (word && !odd)
        rdata <= mem_rdata;
      else if (word)
        rdata[BYTE_W-1:0] <= lane[1];
      else
        rdata <= {ZB, lane[odd]};
    end
  end
endmodule

// File: rtl/lane_bridge.sv
module lane_bridge #(
  parameter int ADDR_W = 16,
  parameter int BYTE_W = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                req_valid,
  input  logic                req_write,
  input  logic                req_word,
  input  logic [ADDR_W-1:0]   req_addr,
  input  logic [2*BYTE_W-1:0] req_wdata,
  output logic                busy,
  output logic                done,
  output logic [2*BYTE_W-1:0] rdata,
  output logic [ADDR_W-2:0]   mem_addr,
  output logic [1:0]          mem_en,
  output logic                mem_we,
  output logic [2*BYTE_W-1:0] mem_wdata,
  input  logic [2*BYTE_W-1:0] mem_rdata,
  input  logic                mem_ready
);
  localparam int DW = 2 * BYTE_W;

  logic              h_write, h_word;
  logic [ADDR_W-1:0] h_addr;
  logic [DW-1:0]     h_wdata;

  logic accept, advance, finish, complete, in_second;

  logic              m_word;
  logic [ADDR_W-1:0] m_addr;
  logic [DW-1:0]     m_wdata;
  logic [1:0]        m_en;
  logic [ADDR_W-2:0] m_waddr;
  logic [DW-1:0]     m_lanes;

  lane_seq u_seq (
    .clk(clk), .rst(rst), .req_valid(req_valid),
    .split(h_word & h_addr[0]), .mem_ready(mem_ready),
    .accept(accept), .advance(advance), .finish(finish),
    .complete(complete), .in_second(in_second),
    .busy(busy), .done(done)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      h_write <= 1'b0;
      h_word  <= 1'b0;
      h_addr  <= '0;
      h_wdata <= '0;
    end else if (accept) begin
      h_write <= req_write;
      h_word  <= req_word;
      h_addr  <= req_addr;
      h_wdata <= req_wdata;
    end
  end

  assign m_word  = accept ? req_word  : h_word;
  assign m_addr  = accept ? req_addr  : h_addr;
  assign m_wdata = accept ? req_wdata : h_wdata;

  lane_map #(.ADDR_W(ADDR_W), .BYTE_W(BYTE_W)) u_map (
    .second(!accept), .word(m_word), .addr(m_addr), .wdata(m_wdata),
    .en(m_en), .waddr(m_waddr), .lanes(m_lanes)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      mem_en    <= 2'b00;
      mem_addr  <= '0;
      mem_we    <= 1'b0;
      mem_wdata <= '0;
    end else if (accept || advance) begin
      mem_en    <= m_en;
      mem_addr  <= m_waddr;
      mem_we    <= accept ? req_write : h_write;
      mem_wdata <= m_lanes;
    end else if (finish) begin
      mem_en <= 2'b00;
      mem_we <= 1'b0;
    end
  end

  lane_gather #(.BYTE_W(BYTE_W)) u_gather (
    .clk(clk), .rst(rst), .capture(complete && !h_write),
    .second(in_second), .word(h_word), .odd(h_addr[0]),
    .mem_rdata(mem_rdata), .rdata(rdata)
  );
endmodule

// File: rtl/lane_bridge_chk.sv
module lane_bridge_chk #(
  parameter int ADDR_W = 16,
  parameter int BYTE_W = 8
) (
  input logic                clk,
  input logic                rst,
  input logic                req_valid,
  input logic [ADDR_W-1:0]   req_addr,
  input logic                req_word,
  input logic                busy,
  input logic                done,
  input logic [ADDR_W-2:0]   mem_addr,
  input logic [1:0]          mem_en,
  input logic                mem_we,
  input logic [2*BYTE_W-1:0] mem_wdata,
  input logic                mem_ready
);
  localparam int WA_W = ADDR_W - 1;
  localparam logic [WA_W-1:0] ONE = WA_W'(1);

  logic c_word, c_odd;
  always_ff @(posedge clk) begin
    if (rst) begin
      c_word <= 1'b0;
      c_odd  <= 1'b0;
    end else if (req_valid && !busy) begin
      c_word <= req_word;
      c_odd  <= req_addr[0];
    end
  end

  a_r1_reset_quiet: assert property (@(posedge clk)
    rst |=> (mem_en == 2'b00 && !busy && !done));

  a_r8_hold_on_stall: assert property (@(posedge clk) disable iff (rst)
    (mem_en != 2'b00 && !mem_ready) |=>
      ($stable(mem_en) && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)));

  a_r9_done_single: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  a_r9_done_idle: assert property (@(posedge clk) disable iff (rst)
    done |-> (!busy && mem_en == 2'b00));

  a_r9_busy_drives: assert property (@(posedge clk) disable iff (rst)
    busy |-> (mem_en != 2'b00));

  a_r5_second_half: assert property (@(posedge clk) disable iff (rst)
    (mem_en == 2'b10 && mem_ready && c_word) |=>
      (mem_en == 2'b01 && mem_addr == $past(mem_addr) + ONE));

  a_r4_both_banks: assert property (@(posedge clk) disable iff (rst)
    (mem_en == 2'b11) |-> (c_word && !c_odd));

  a_r2_byte_bank: assert property (@(posedge clk) disable iff (rst)
    (busy && !c_word) |-> (mem_en == (c_odd ? 2'b10 : 2'b01)));
endmodule

bind lane_bridge lane_bridge_chk #(.ADDR_W(ADDR_W), .BYTE_W(BYTE_W)) u_chk (
  .clk(clk), .rst(rst), .req_valid(req_valid), .req_addr(req_addr),
  .req_word(req_word), .busy(busy), .done(done), .mem_addr(mem_addr),
  .mem_en(mem_en), .mem_we(mem_we), .mem_wdata(mem_wdata),
  .mem_ready(mem_ready)
);

// File: tb/sim_lane_bridge.sv
`timescale 1ns/1ps
module sim_lane_bridge;
  localparam int AW = 10;
  localparam int NB = 1 << AW;
  localparam int NW = NB / 2;
  localparam logic [AW-1:0] GHOST = 10'h005;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #10 clk = ~clk;

  logic          req_valid = 0, req_write = 0, req_word = 0;
  logic [AW-1:0] req_addr = '0;
  logic [15:0]   req_wdata = '0;
  logic          busy, done, mem_we;
  logic [15:0]   rdata, mem_wdata, mem_rdata;
  logic [AW-2:0] mem_addr;
  logic [1:0]    mem_en;
  logic          mem_ready = 1'b1;

  lane_bridge #(.ADDR_W(AW), .BYTE_W(8)) u0 (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .req_word(req_word), .req_addr(req_addr), .req_wdata(req_wdata),
    .busy(busy), .done(done), .rdata(rdata), .mem_addr(mem_addr),
    .mem_en(mem_en), .mem_we(mem_we), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .mem_ready(mem_ready)
  );

  logic [7:0] lo_bank [NW];
  logic [7:0] hi_bank [NW];
  logic [7:0] ref_mem [NB];

  assign mem_rdata = {hi_bank[mem_addr], lo_bank[mem_addr]};

  int cyc_cnt = 0;
  logic [1:0]    log_en0, log_en1;
  logic [AW-2:0] log_ad0, log_ad1;
  always @(posedge clk) begin
    if (!rst && mem_en != 2'b00 && mem_ready) begin
      if (mem_we) begin
        if (mem_en[0]) lo_bank[mem_addr] <= mem_wdata[7:0];
        if (mem_en[1]) hi_bank[mem_addr] <= mem_wdata[15:8];
      end
      cyc_cnt <= cyc_cnt + 1;
      log_en1 <= log_en0; log_ad1 <= log_ad0;
      log_en0 <= mem_en;  log_ad0 <= mem_addr;
    end
  end

  int checks = 0, fails = 0;
  bit finished = 0;

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] bank_byte(input logic [AW-1:0] a);
    return a[0] ? hi_bank[a[AW-1:1]] : lo_bank[a[AW-1:1]];
  endfunction

  function automatic logic [15:0] exp_read(input logic [AW-1:0] a, input bit wd);
    logic [AW-1:0] a1;
    a1 = a + 1'b1;
    return wd ? {ref_mem[a1], ref_mem[a]} : {8'h00, ref_mem[a]};
  endfunction

  task automatic run_op(input bit wr, input bit wd, input logic [AW-1:0] a,
                        input logic [15:0] wdat, input bit stall, input bit ghost);
    int c0;
    bit seen;
    logic [15:0] er;
    logic [AW-1:0] a1;
    logic [1:0] pv_en;
    logic [AW-2:0] pv_ad;
    logic [15:0] pv_wd;
    logic pv_rdy;
    string rq;
    a1 = a + 1'b1;
    er = exp_read(a, wd);
    rq = !wd ? "R2" : (a[0] ? "R5" : "R4");
    @(negedge clk);
    req_valid = 1; req_write = wr; req_word = wd; req_addr = a; req_wdata = wdat;
    c0 = cyc_cnt;
    @(negedge clk);
    if (ghost) begin
      req_write = 1; req_word = 0; req_addr = GHOST; req_wdata = 16'h005A ^ {8'h00, ref_mem[GHOST]};
    end else begin
      req_valid = 0;
    end
    chk("R9", "busy after accept", {31'd0, busy}, 32'd1);
    seen = 0; pv_en = 2'b00; pv_ad = '0; pv_wd = '0; pv_rdy = 1;
    for (int i = 0; i < 300; i++) begin
      if (done) begin seen = 1; break; end
      if (pv_en != 2'b00 && !pv_rdy)
        chk("R8", "bus held during stall", {mem_en, mem_addr, mem_wdata},
            {pv_en, pv_ad, pv_wd});
      mem_ready = stall ? (($urandom % 3) != 0) : 1'b1;
      pv_en = mem_en; pv_ad = mem_addr; pv_wd = mem_wdata; pv_rdy = mem_ready;
      @(negedge clk);
    end
    req_valid = 0;
    mem_ready = 1;
    chk("R9", "done reached", {31'd0, seen}, 32'd1);
    chk("R9", "busy low with done", {31'd0, busy}, 32'd0);
    chk(rq, "bus cycle count", cyc_cnt - c0, (wd && a[0]) ? 32'd2 : 32'd1);
    if (wd && a[0]) begin
      chk("R5", "first cycle enables", {30'd0, log_en1}, 32'd2);
      chk("R5", "first cycle address", {23'd0, log_ad1}, {23'd0, a[AW-1:1]});
      chk("R5", "second cycle enables", {30'd0, log_en0}, 32'd1);
      chk("R5", "second cycle address", {23'd0, log_ad0}, {23'd0, a[AW-1:1] + 9'd1});
    end else begin
      chk(rq, "cycle enables", {30'd0, log_en0},
          wd ? 32'd3 : (a[0] ? 32'd2 : 32'd1));
      chk(rq, "cycle address", {23'd0, log_ad0}, {23'd0, a[AW-1:1]});
    end
    if (!wr) begin
      chk(!wd ? "R3" : (a[0] ? "R6" : "R4"), "read data", {16'd0, rdata}, {16'd0, er});
    end else begin
      ref_mem[a] = wdat[7:0];
      if (wd) ref_mem[a1] = wdat[15:8];
      for (int d = -1; d <= 2; d++) begin
        logic [AW-1:0] t;
        t = a + AW'(d);
        chk(!wd ? "R2" : (a[0] ? "R7" : "R4"), "stored byte",
            {24'd0, bank_byte(t)}, {24'd0, ref_mem[t]});
      end
    end
    chk("R10", "ghost byte untouched", {24'd0, bank_byte(GHOST)}, {24'd0, ref_mem[GHOST]});
    @(negedge clk);
    chk("R9", "done is one cycle", {31'd0, done}, 32'd0);
    chk("R9", "bus idle after done", {30'd0, mem_en}, 32'd0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog run did not end actual=%h expected=%h", 0, 1);
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    for (int i = 0; i < NW; i++) begin
      lo_bank[i] = 8'($urandom);
      hi_bank[i] = 8'($urandom);
      ref_mem[2*i]   = lo_bank[i];
      ref_mem[2*i+1] = hi_bank[i];
    end
    repeat (3) @(negedge clk);
    chk("R1", "busy in reset", {31'd0, busy}, 32'd0);
    chk("R1", "enables in reset", {30'd0, mem_en}, 32'd0);
    rst = 0;
    @(negedge clk);
    chk("R1", "done after reset", {31'd0, done}, 32'd0);
    chk("R1", "enables after reset", {30'd0, mem_en}, 32'd0);
    chk("R1", "busy after reset", {31'd0, busy}, 32'd0);

    // directed corners
    run_op(0, 1, 10'h010, 16'h0, 0, 0);          // aligned word read
    run_op(1, 1, 10'h020, 16'hBEEF, 0, 0);       // aligned word write
    run_op(0, 1, 10'h020, 16'h0, 1, 0);
    run_op(1, 1, 10'h031, 16'h1234, 0, 0);       // split write
    run_op(0, 1, 10'h031, 16'h0, 1, 0);          // split read
    run_op(0, 1, 10'h030, 16'h0, 0, 0);
    run_op(1, 1, 10'h3FF, 16'hA55A, 1, 0);       // wrap at top
    run_op(0, 1, 10'h3FF, 16'h0, 0, 0);
    run_op(1, 0, 10'h040, 16'hFF11, 0, 0);       // even byte write
    run_op(1, 0, 10'h043, 16'hEE22, 1, 0);       // odd byte write
    run_op(0, 0, 10'h043, 16'h0, 0, 0);
    run_op(0, 0, 10'h040, 16'h0, 1, 0);
    run_op(1, 1, 10'h101, 16'h7788, 1, 1);       // stray request while busy
    run_op(0, 0, GHOST, 16'h0, 0, 0);

    for (int n = 0; n < 400; n++) begin
      run_op($urandom % 2, $urandom % 2, AW'($urandom), 16'($urandom),
             $urandom % 2, ($urandom % 8) == 0);
    end

    finished = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule